// File: doc/BRIEF.md
# Timer-Chip Interrupt Control Unit

This block gathers interrupt events from the five event sources of a timer and I/O chip. The sources are two timer underflows, a time-of-day alarm, the serial shifter and an external flag pin. Each source gives a one-cycle trigger pulse. The block latches every pulse into a pending-flag word. A software-written enable mask chooses which pending sources may pull the active-low CPU interrupt line.

The interrupt line never follows a trigger within the same cycle. A qualifying event first arms an internal "raise scheduled" flag, and the line falls on the following edge. On that same edge the summary request bit (bit 7 of the read word) becomes 1. A read of the status word acknowledges it. The acknowledge clears the pending flags and the summary bit and releases the line. An armed schedule from the previous cycle is dropped by the acknowledge unless a new enabled event arrives with it. This settles the race between an acknowledge and a trigger without sending the CPU a spurious or lost interrupt.

Every register access completes in one cycle. The block applies no back-pressure and has no valid/ready handshake. A write strobe or a read strobe held high for one cycle is one access. The status word is shown on `status_o` at all times. Asserting `rd_ack` marks that word as consumed.

Top module: `tic_irq_ctrl`

## Requirements
- R1: After synchronous reset, `status_o` reads 0x00, the enable mask is empty, `irq_n` is 1, and no interrupt is raised until a new enabled event arrives.
- R2: A one-cycle pulse on `src_trig[i]` sets bit i of `status_o` from the next cycle on. The bit positions are: 0 timer A underflow, 1 timer B underflow, 2 alarm, 3 serial, 4 flag pin.
- R3: A write with `wr_data[7]`=1 sets the enable bits that are 1 in `wr_data[4:0]`. A write with `wr_data[7]`=0 clears those enable bits. Enable bits at 0 positions in `wr_data[4:0]` keep their value.
- R4: A trigger on a source whose enable bit is 0 latches its status bit but leaves `irq_n` at 1 and `status_o[7]` at 0.
- R5: For an enabled trigger pulsed in cycle t, `irq_n` goes to 0 and `status_o[7]` goes to 1 from cycle t+2 on.
- R6: In a cycle with `rd_ack`=1, `status_o` still shows the old word. From the next cycle on, the word is 0x00 (apart from triggers in that same cycle) and `irq_n` is 1.
- R7: A trigger in the same cycle as `rd_ack` survives the clear. If that source is enabled, `irq_n` falls again one cycle after the acknowledge takes effect.
- R8: An acknowledge in the cycle directly after an enabled trigger (before the line has fallen) cancels the scheduled raise. `irq_n` then stays 1.
- R9: A mask write that sets the enable bit of an already pending source raises the interrupt with the same delay as a trigger: `irq_n` is 0 from two cycles after the write.
- R10: Bits 6 and 5 of `status_o` always read 0.
- R11: Further triggers while the line is low or a raise is scheduled cause no extra edge. `irq_n` stays 0 until an acknowledge.
- R12: A reset taken while the interrupt is raised or scheduled releases `irq_n` and drops the schedule.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_trig | input | 5 | One-cycle event pulses, one per source |
| wr_en | input | 1 | Mask write strobe |
| wr_data | input | 8 | Mask write word: bit 7 selects set or clear, bits 4..0 select sources |
| rd_ack | input | 1 | Status read strobe; acknowledges and clears |
| status_o | output | 8 | Status word: bit 7 summary request, bits 4..0 pending sources |
| irq_n | output | 1 | Registered active-low interrupt request |

## Verification
The bench builds the block with its default parameters: five sources, an 8-bit word and the summary request at bit 7. With these values every source position is reachable, as are the zero padding at bits 6 and 5 and the set/clear selector at the top bit. The stimulus lines up acknowledges, mask writes and triggers in adjacent cycles. This brings the same-cycle survival case, the cancelled schedule and the delayed raise after a mask write within reach, next to plain single-source traffic.

// File: rtl/tic_irq_pkg.sv
package tic_irq_pkg;
  localparam int unsigned NUM_SRC  = 5;
  localparam int unsigned WORD_W   = 8;
  localparam int unsigned SUM_BIT  = 7;

  typedef enum logic [2:0] {
    SRC_TMR_A  = 3'd0,
    SRC_TMR_B  = 3'd1,
    SRC_ALARM  = 3'd2,
    SRC_SERIAL = 3'd3,
    SRC_FLAG   = 3'd4
  } src_id_e;
endpackage

// File: rtl/tic_mask_reg.sv
module tic_mask_reg #(
  parameter int unsigned NSRC = tic_irq_pkg::NUM_SRC,
  parameter int unsigned DW   = tic_irq_pkg::WORD_W,
  parameter int unsigned SELB = tic_irq_pkg::SUM_BIT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  output logic [NSRC-1:0] en_q,
  output logic [NSRC-1:0] en_next
);
  logic set_mode;
  assign set_mode = wr_data[SELB];

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    always_comb begin
      en_next[i] = en_q[i];
      if (wr_en && wr_data[i]) en_next[i] = set_mode;
    end

    always_ff @(posedge clk) begin
      if (rst) en_q[i] <= 1'b0;
      else     en_q[i] <= en_next[i];
    end

    // R3
    mask_set_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && wr_data[SELB] && wr_data[i]) |=> en_q[i]);
    // R3
    mask_clr_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !wr_data[SELB] && wr_data[i]) |=> !en_q[i]);
  end
endmodule

// File: rtl/tic_flag_reg.sv
module tic_flag_reg #(
  parameter int unsigned NSRC = tic_irq_pkg::NUM_SRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ack,
  input  logic [NSRC-1:0] trig,
  output logic [NSRC-1:0] flag_q,
  output logic [NSRC-1:0] flag_next
);
  always_comb begin
    flag_next = ack ? '0 : flag_q;
    flag_next = flag_next | trig;
  end

  always_ff @(posedge clk) begin
    if (rst) flag_q <= '0;
    else     flag_q <= flag_next;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R2
    trig_latch_chk: assert property (@(posedge clk) disable iff (rst)
      trig[i] |=> flag_q[i]);
  end
endmodule

// File: rtl/tic_irq_seq.sv
module tic_irq_seq #(
  parameter int unsigned NSRC = tic_irq_pkg::NUM_SRC
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ack,
  input  logic [NSRC-1:0] flag_next,
  input  logic [NSRC-1:0] en_next,
  output logic            req_q,
  output logic            irq_n
);
  logic armed_q;
  logic req_next;
  logic arm_next;

  always_comb begin
    if (ack)          req_next = 1'b0;
    else if (armed_q) req_next = 1'b1;
    else              req_next = req_q;
    arm_next = (|(flag_next & en_next)) && !req_next;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      req_q   <= 1'b0;
      irq_n   <= 1'b1;
    end else begin
      armed_q <= arm_next;
      req_q   <= req_next;
      irq_n   <= !req_next;
    end
  end

  // R6
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    ack |=> irq_n);
  // R5
  armed_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (armed_q && !ack) |=> !irq_n);
  // R11
  hold_low_chk: assert property (@(posedge clk) disable iff (rst)
    (!irq_n && !ack) |=> !irq_n);
endmodule

// File: rtl/tic_irq_ctrl.sv
module tic_irq_ctrl #(
  parameter int unsigned NSRC = tic_irq_pkg::NUM_SRC,
  parameter int unsigned DW   = tic_irq_pkg::WORD_W,
  parameter int unsigned SUMB = tic_irq_pkg::SUM_BIT
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_trig,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_ack,
  output logic [DW-1:0]   status_o,
  output logic            irq_n
);
  logic [NSRC-1:0] en_q, en_next;
  logic [NSRC-1:0] flag_q, flag_next;
  logic            req_q;

  tic_mask_reg #(.NSRC(NSRC), .DW(DW), .SELB(SUMB)) u_mask (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .en_q(en_q), .en_next(en_next));

  tic_flag_reg #(.NSRC(NSRC)) u_flag (
    .clk(clk), .rst(rst), .ack(rd_ack), .trig(src_trig),
    .flag_q(flag_q), .flag_next(flag_next));

  tic_irq_seq #(.NSRC(NSRC)) u_seq (
    .clk(clk), .rst(rst), .ack(rd_ack), .flag_next(flag_next),
    .en_next(en_next), .req_q(req_q), .irq_n(irq_n));

  always_comb begin
    status_o             = '0;
    status_o[NSRC-1:0]   = flag_q;
    status_o[SUMB]       = req_q;
  end

  // R4
  masked_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_n && ((flag_q & en_q) == '0) && !wr_en && ((src_trig & en_q) == '0)) |=> irq_n);
  // R6
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_ack && src_trig == '0) |=> (status_o[NSRC-1:0] == '0));
endmodule

// File: tb/tic_irq_ctrl_test.sv
`timescale 1ns/1ps
module tic_irq_ctrl_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [4:0] src_trig = '0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_ack = 1'b0;
  logic [7:0] status_o;
  logic       irq_n;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;
  string tag  = "R1";
  bit    live = 1'b0;
  bit    done = 1'b0;

  // reference model state
  bit [4:0] m_flags = '0;
  bit [4:0] m_en    = '0;
  bit       m_req   = 1'b0;
  int       m_raise_at = -1;   // cycle index at which the line falls

  always #5 clk = ~clk;

  tic_irq_ctrl uut (
    .clk(clk), .rst(rst), .src_trig(src_trig), .wr_en(wr_en),
    .wr_data(wr_data), .rd_ack(rd_ack), .status_o(status_o), .irq_n(irq_n));

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (rst) begin
      m_flags = '0; m_en = '0; m_req = 0; m_raise_at = -1;
      live = 1'b1;
    end else begin
      if (rd_ack) begin m_flags = '0; m_req = 0; m_raise_at = -1; end
      else if (m_raise_at == cycles) begin m_req = 1; m_raise_at = -1; end
      m_flags = m_flags | src_trig;
      if (wr_en)
        for (int k = 0; k < 5; k++)
          if (wr_data[k]) m_en[k] = wr_data[7];
      if (!m_req && m_raise_at < 0 && (m_flags & m_en) != 0)
        m_raise_at = cycles + 1;
    end
  end

  task automatic cmp(string r, logic [7:0] act, logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", r, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (live && !done) begin
      cmp({tag, " status"}, status_o, {m_req, 2'b00, m_flags});
      cmp({tag, " irq_n"}, {7'd0, irq_n}, {7'd0, ~m_req});
    end
  end

  task automatic step(input logic [4:0] t, input logic rd, input logic we,
                      input logic [7:0] wd);
    @(negedge clk);
    src_trig = t; rd_ack = rd; wr_en = we; wr_data = wd;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(5'd0, 0, 0, 8'h00);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tag = "R1"; idle(3);
    @(negedge clk); cmp("R1 reset word", status_o, 8'h00);
    tag = "R2"; step(5'b00001, 0, 0, 0); step(5'b00100, 0, 0, 0);
    step(5'b10000, 0, 0, 0); idle(2);
    @(negedge clk); cmp("R2 flags latched", status_o, 8'h15);
    tag = "R4"; idle(3);
    @(negedge clk); cmp("R4 masked quiet", {7'd0, irq_n}, 8'h01);
    tag = "R6"; step(0, 1, 0, 0); idle(2);
    @(negedge clk); cmp("R6 cleared", status_o, 8'h00);
    tag = "R3"; step(0, 0, 1, 8'h83); step(0, 0, 1, 8'h01); idle(1);
    tag = "R5"; step(5'b00010, 0, 0, 0); step(0, 0, 0, 0); step(0, 0, 0, 0);
    @(negedge clk); cmp("R5 raised", {status_o[7], 6'd0, irq_n}, 8'h80);
    tag = "R11"; step(5'b00010, 0, 0, 0); step(5'b00011, 0, 0, 0); idle(3);
    @(negedge clk); cmp("R11 still low", {7'd0, irq_n}, 8'h00);
    tag = "R7"; step(5'b00010, 1, 0, 0); idle(3);
    @(negedge clk); cmp("R7 reraised", status_o, 8'h82);
    tag = "R8"; step(0, 1, 0, 0); idle(1); step(5'b00010, 0, 0, 0);
    step(0, 1, 0, 0); idle(3);
    @(negedge clk); cmp("R8 cancelled", {status_o[7], 6'd0, irq_n}, 8'h01);
    tag = "R9"; step(5'b01000, 0, 0, 0); idle(3);
    step(0, 0, 1, 8'h88); idle(3);
    @(negedge clk); cmp("R9 raised by mask", status_o, 8'h88);
    tag = "R10"; step(5'b11111, 0, 0, 0); idle(2);
    @(negedge clk); cmp("R10 padding", status_o & 8'h60, 8'h00);
    tag = "R3"; step(0, 1, 1, 8'h1F); idle(1); step(5'b11111, 0, 0, 0); idle(3);
    @(negedge clk); cmp("R3 all cleared", {7'd0, irq_n}, 8'h01);
    tag = "R12"; step(0, 1, 1, 8'h81); idle(1); step(5'b00001, 0, 0, 0);
    @(negedge clk); rst = 1'b1; src_trig = 0;
    @(negedge clk); rst = 1'b0; idle(3);
    @(negedge clk); cmp("R12 released", {status_o[7], 6'd0, irq_n}, 8'h01);
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule